// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block keeps a small bank of one-bit ownership flags that two independent agents, a left port and a right port, use to coordinate access to a shared resource. Both ports run on one clock. Each port has a strobe, a direction bit, a flag index and a single write-data bit. A port asks for a flag by writing 0 to it and gives the flag back by writing 1. To learn whether it holds the flag, the port reads the flag back. The flag reads 0 to its owner and 1 to everyone else, so a flag that nobody owns reads 1 to both ports.

Each port keeps one pending request per flag. A request that loses stays pending. When the owner releases the flag, the pending request is granted with no further write. If both ports request the same free flag in the same cycle, a fixed tie-break picks one winner. By default the left port wins. A semaphore strobe only takes effect when the port's semaphore select is high and the port is not addressing the ordinary memory. A port is addressing memory when its memory enable is high and at least one of its byte lanes is enabled.

Top module: `dpsem_unit`

## Requirements
- R1: After reset, every flag is free and no request is pending. Both read-data outputs hold all ones.
- R2: A strobe acts only when `x_sem_sel` is 1 and either `x_mem_en` is 0 or both bits of `x_lane_en` are 0. Any other strobe changes neither the flags, the pending requests nor the read data.
- R3: A write with data bit 0 to a free flag grants that flag to the writing port. The flag then reads 0 on that port and 1 on the other port.
- R4: A read strobe (`x_we`=0) updates `x_rdata` on the clock edge that samples the strobe. All `DATA_W` bits of `x_rdata` equal the flag value seen by that port. Between read strobes, `x_rdata` holds its value.
- R5: A write with data bit 1 from the owning port frees the flag, unless the other port has a request pending for it. A freed flag reads 1 on both ports.
- R6: If both ports request the same free flag in one cycle, only the left port is granted (parameter `TIE_LEFT`=1). The right port's request stays pending. No flag is ever owned by both ports.
- R7: A pending request is granted on the same edge on which the owner's release takes effect, with no new write.
- R8: A release write from a port that does not own the flag clears only that port's pending request. The owner is unchanged.
- R9: Operations on one flag index never change any other flag.
- R10: A read in the cycle after a write returns the state that the write produced.
- R11: A request write from the port that already owns the flag has no effect. One release then frees the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_valid | input | 1 | Left strobe |
| l_sem_sel | input | 1 | Left semaphore select |
| l_mem_en | input | 1 | Left memory enable (blocks the semaphore when any lane is also on) |
| l_lane_en | input | 2 | Left byte-lane enables |
| l_we | input | 1 | Left write (1) or read (0) |
| l_idx | input | 3 | Left flag index |
| l_wbit | input | 1 | Left write bit: 0 requests, 1 releases |
| l_rdata | output | 16 | Left registered read data |
| r_valid | input | 1 | Right strobe |
| r_sem_sel | input | 1 | Right semaphore select |
| r_mem_en | input | 1 | Right memory enable |
| r_lane_en | input | 2 | Right byte-lane enables |
| r_we | input | 1 | Right write (1) or read (0) |
| r_idx | input | 3 | Right flag index |
| r_wbit | input | 1 | Right write bit: 0 requests, 1 releases |
| r_rdata | output | 16 | Right registered read data |

## Verification
Two functions can fall on the same edge.

- **Request collision.** Both ports write a request to one free flag in the same cycle. The next cycle reads that flag from both sides and expects 0 on the left and 1 on the right. The left port then releases the flag. A read one cycle later must show the right port as owner, even though it made no second write.
- **Release with a rival request pending.** One port releases a flag at the moment the other port's request is pending. The bench judges the result from the next read on each port, and a checker watches that no flag is ever owned by both ports.

// File: rtl/dpsem_pkg.sv
package dpsem_pkg;

   typedef enum logic [1:0] {
      HOLD_NONE  = 2'd0,
      HOLD_LEFT  = 2'd1,
      HOLD_RIGHT = 2'd2
   } holder_e;

   typedef struct packed {
      logic rd;
      logic req;
      logic rel;
   } sem_cmd_t;

endpackage

// File: rtl/dpsem_gate.sv
module dpsem_gate
   import dpsem_pkg::*;
#(
   parameter int IDX_W = 3,
   parameter int LANES = 2,
   localparam int NUM_FLAGS = 1 << IDX_W
) (
   input  logic                 valid,
   input  logic                 sem_sel,
   input  logic                 mem_en,
   input  logic [LANES-1:0]     lane_en,
   input  logic                 we,
   input  logic                 wbit,
   input  logic [IDX_W-1:0]     idx,
   output sem_cmd_t             cmd,
   output logic [NUM_FLAGS-1:0] hit
);

   logic go;

   // semaphore cycle only when the port is not addressing ordinary memory
   assign go = valid & sem_sel & (~mem_en | ~(|lane_en));

   always_comb begin
      cmd.rd  = go & ~we;
      cmd.req = go & we & ~wbit;
      cmd.rel = go & we & wbit;
   end

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_hit
      assign hit[g] = go & (idx == IDX_W'(g));
   end

endmodule

// File: rtl/dpsem_flag.sv
module dpsem_flag
   import dpsem_pkg::*;
#(
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic l_req,
   input  logic l_rel,
   input  logic r_req,
   input  logic r_rel,
   output logic own_l,
   output logic own_r
);

   holder_e holder_q, holder_mid, holder_d;
   logic    pend_l_q, pend_r_q;
   logic    pend_l_mid, pend_r_mid;
   logic    pend_l_d, pend_r_d;

   always_comb begin
      holder_mid = holder_q;
      if ((l_rel && holder_q == HOLD_LEFT) || (r_rel && holder_q == HOLD_RIGHT))
         holder_mid = HOLD_NONE;
      pend_l_mid = l_rel ? 1'b0 : (pend_l_q | (l_req & (holder_q != HOLD_LEFT)));
      pend_r_mid = r_rel ? 1'b0 : (pend_r_q | (r_req & (holder_q != HOLD_RIGHT)));
   end

   if (TIE_LEFT) begin : g_left_first
      always_comb begin
         holder_d = holder_mid;
         pend_l_d = pend_l_mid;
         pend_r_d = pend_r_mid;
         if (holder_mid == HOLD_NONE) begin
            if (pend_l_mid) begin
               holder_d = HOLD_LEFT;
               pend_l_d = 1'b0;
            end else if (pend_r_mid) begin
               holder_d = HOLD_RIGHT;
               pend_r_d = 1'b0;
            end
         end
      end
   end else begin : g_right_first
      always_comb begin
         holder_d = holder_mid;
         pend_l_d = pend_l_mid;
         pend_r_d = pend_r_mid;
         if (holder_mid == HOLD_NONE) begin
            if (pend_r_mid) begin
               holder_d = HOLD_RIGHT;
               pend_r_d = 1'b0;
            end else if (pend_l_mid) begin
               holder_d = HOLD_LEFT;
               pend_l_d = 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         holder_q <= HOLD_NONE;
         pend_l_q <= 1'b0;
         pend_r_q <= 1'b0;
      end else begin
         holder_q <= holder_d;
         pend_l_q <= pend_l_d;
         pend_r_q <= pend_r_d;
      end
   end

   assign own_l = (holder_q == HOLD_LEFT);
   assign own_r = (holder_q == HOLD_RIGHT);

endmodule

// File: rtl/dpsem_rdport.sv
module dpsem_rdport #(
   parameter int IDX_W  = 3,
   parameter int DATA_W = 16,
   localparam int NUM_FLAGS = 1 << IDX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd,
   input  logic [IDX_W-1:0]     idx,
   input  logic [NUM_FLAGS-1:0] own,
   output logic [DATA_W-1:0]    rdata
);

   logic seen;

   assign seen = ~own[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '1;
      else if (rd)
         rdata <= {DATA_W{seen}};
   end

endmodule

// File: rtl/dpsem_unit.sv
module dpsem_unit
   import dpsem_pkg::*;
#(
   parameter int IDX_W    = 3,
   parameter int DATA_W   = 16,
   parameter int LANES    = 2,
   parameter bit TIE_LEFT = 1'b1,
   localparam int NUM_FLAGS = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_valid,
   input  logic              l_sem_sel,
   input  logic              l_mem_en,
   input  logic [LANES-1:0]  l_lane_en,
   input  logic              l_we,
   input  logic [IDX_W-1:0]  l_idx,
   input  logic              l_wbit,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_valid,
   input  logic              r_sem_sel,
   input  logic              r_mem_en,
   input  logic [LANES-1:0]  r_lane_en,
   input  logic              r_we,
   input  logic [IDX_W-1:0]  r_idx,
   input  logic              r_wbit,
   output logic [DATA_W-1:0] r_rdata
);

   if (IDX_W < 1 || IDX_W > 6) begin : g_bad_idx
      $error("dpsem_unit: IDX_W must be within 1..6");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dpsem_unit: DATA_W must be positive");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("dpsem_unit: LANES must be positive");
   end

   sem_cmd_t             l_cmd, r_cmd;
   logic [NUM_FLAGS-1:0] l_hit, r_hit;
   logic [NUM_FLAGS-1:0] own_l, own_r;
   logic                 l_rd_go, r_rd_go, l_rel_go, r_rel_go;

   dpsem_gate #(.IDX_W(IDX_W), .LANES(LANES)) i_gate_l (
      .valid(l_valid), .sem_sel(l_sem_sel), .mem_en(l_mem_en), .lane_en(l_lane_en),
      .we(l_we), .wbit(l_wbit), .idx(l_idx), .cmd(l_cmd), .hit(l_hit)
   );

   dpsem_gate #(.IDX_W(IDX_W), .LANES(LANES)) i_gate_r (
      .valid(r_valid), .sem_sel(r_sem_sel), .mem_en(r_mem_en), .lane_en(r_lane_en),
      .we(r_we), .wbit(r_wbit), .idx(r_idx), .cmd(r_cmd), .hit(r_hit)
   );

   assign l_rd_go  = l_cmd.rd;
   assign r_rd_go  = r_cmd.rd;
   assign l_rel_go = l_cmd.rel;
   assign r_rel_go = r_cmd.rel;

   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      dpsem_flag #(.TIE_LEFT(TIE_LEFT)) i_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .l_req (l_cmd.req & l_hit[f]),
         .l_rel (l_cmd.rel & l_hit[f]),
         .r_req (r_cmd.req & r_hit[f]),
         .r_rel (r_cmd.rel & r_hit[f]),
         .own_l (own_l[f]),
         .own_r (own_r[f])
      );
   end

   dpsem_rdport #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_rd_l (
      .clk(clk), .rst_n(rst_n), .rd(l_cmd.rd), .idx(l_idx), .own(own_l), .rdata(l_rdata)
   );

   dpsem_rdport #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_rd_r (
      .clk(clk), .rst_n(rst_n), .rd(r_cmd.rd), .idx(r_idx), .own(own_r), .rdata(r_rdata)
   );

endmodule

// File: rtl/dpsem_chk.sv
module dpsem_chk #(
   parameter int IDX_W  = 3,
   parameter int DATA_W = 16,
   localparam int NUM_FLAGS = 1 << IDX_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [DATA_W-1:0]    l_rdata,
   input logic [DATA_W-1:0]    r_rdata,
   input logic [IDX_W-1:0]     l_idx,
   input logic [IDX_W-1:0]     r_idx,
   input logic                 l_rd_go,
   input logic                 r_rd_go,
   input logic                 l_rel_go,
   input logic                 r_rel_go,
   input logic [NUM_FLAGS-1:0] own_l,
   input logic [NUM_FLAGS-1:0] own_r
);

   // R6: a flag never has two holders
   p_single_holder_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l & own_r) == '0);

   // R4: every bit of the read word carries the same value
   p_uniform_l_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rdata == '0) || (l_rdata == '1));
   p_uniform_r_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (r_rdata == '0) || (r_rdata == '1));

   // R4: read data holds between read strobes
   p_hold_l_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !l_rd_go |=> $stable(l_rdata));
   p_hold_r_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !r_rd_go |=> $stable(r_rdata));

   // R3: a read returns the holder state seen at the strobe
   p_read_value_l_r3: assert property (@(posedge clk) disable iff (!rst_n)
      l_rd_go |=> (l_rdata[0] == !$past(own_l[l_idx])));
   p_read_value_r_r3: assert property (@(posedge clk) disable iff (!rst_n)
      r_rd_go |=> (r_rdata[0] == !$past(own_r[r_idx])));

   // R5: an owner release removes that owner
   p_release_l_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rel_go && own_l[l_idx]) |=> !own_l[$past(l_idx)]);
   p_release_r_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (r_rel_go && own_r[r_idx]) |=> !own_r[$past(r_idx)]);

endmodule

bind dpsem_unit dpsem_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_dpsem_chk (
   .clk(clk), .rst_n(rst_n), .l_rdata(l_rdata), .r_rdata(r_rdata),
   .l_idx(l_idx), .r_idx(r_idx), .l_rd_go(l_rd_go), .r_rd_go(r_rd_go),
   .l_rel_go(l_rel_go), .r_rel_go(r_rel_go), .own_l(own_l), .own_r(own_r)
);

// File: tb/test_dpsem_unit.sv
module test_dpsem_unit;

   localparam int CLK_PERIOD = 10;

   localparam logic [1:0] OP_IDLE = 2'd0;
   localparam logic [1:0] OP_RD   = 2'd1;
   localparam logic [1:0] OP_REQ  = 2'd2;
   localparam logic [1:0] OP_REL  = 2'd3;

   typedef struct packed {
      logic [1:0] lop;
      logic [2:0] lidx;
      logic [1:0] rop;
      logic [2:0] ridx;
      logic       lchk;
      logic       lexp;
      logic       rchk;
      logic       rexp;
      logic [3:0] tag;
   } vec_t;

   localparam int NSTEP = 23;
   localparam vec_t TBL [NSTEP] = '{
      '{OP_RD,  3'd0, OP_RD,  3'd5, 1'b1, 1'b1, 1'b1, 1'b1, 4'd1},  // R1 free after reset
      '{OP_REQ, 3'd2, OP_IDLE,3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
      '{OP_RD,  3'd2, OP_RD,  3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 4'd3},  // R3 R10 grant seen next cycle
      '{OP_REL, 3'd2, OP_IDLE,3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},
      '{OP_RD,  3'd2, OP_RD,  3'd2, 1'b1, 1'b1, 1'b1, 1'b1, 4'd5},  // R5 freed
      '{OP_REQ, 3'd3, OP_REQ, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 collision
      '{OP_RD,  3'd3, OP_RD,  3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 left wins
      '{OP_REL, 3'd3, OP_IDLE,3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},
      '{OP_RD,  3'd3, OP_RD,  3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 handover
      '{OP_IDLE,3'd0, OP_REL, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},
      '{OP_RD,  3'd3, OP_RD,  3'd3, 1'b1, 1'b1, 1'b1, 1'b1, 4'd5},  // R5 right release
      '{OP_REQ, 3'd6, OP_REQ, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},
      '{OP_RD,  3'd6, OP_RD,  3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 4'd9},  // R9 separate flags
      '{OP_RD,  3'd4, OP_RD,  3'd6, 1'b1, 1'b1, 1'b1, 1'b1, 4'd9},  // R9 cross view
      '{OP_RD,  3'd5, OP_RD,  3'd7, 1'b1, 1'b1, 1'b1, 1'b1, 4'd9},  // R9 neighbours untouched
      '{OP_REQ, 3'd4, OP_IDLE,3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // left pends on 4
      '{OP_REL, 3'd4, OP_RD,  3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 non-owner release
      '{OP_IDLE,3'd0, OP_REL, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},
      '{OP_RD,  3'd4, OP_RD,  3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 4'd8},  // R8 pend was cleared
      '{OP_REQ, 3'd6, OP_IDLE,3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 owner re-request
      '{OP_RD,  3'd6, OP_RD,  3'd6, 1'b1, 1'b0, 1'b1, 1'b1, 4'd11},
      '{OP_REL, 3'd6, OP_IDLE,3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11},
      '{OP_RD,  3'd6, OP_RD,  3'd6, 1'b1, 1'b1, 1'b1, 1'b1, 4'd11}  // R11 one release frees
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        l_valid = 1'b0, l_sem_sel = 1'b1, l_mem_en = 1'b0, l_we = 1'b0, l_wbit = 1'b0;
   logic        r_valid = 1'b0, r_sem_sel = 1'b1, r_mem_en = 1'b0, r_we = 1'b0, r_wbit = 1'b0;
   logic [1:0]  l_lane_en = 2'b00, r_lane_en = 2'b00;
   logic [2:0]  l_idx = '0, r_idx = '0;
   logic [15:0] l_rdata, r_rdata;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dpsem_unit i_dpsem_unit (
      .clk(clk), .rst_n(rst_n),
      .l_valid(l_valid), .l_sem_sel(l_sem_sel), .l_mem_en(l_mem_en), .l_lane_en(l_lane_en),
      .l_we(l_we), .l_idx(l_idx), .l_wbit(l_wbit), .l_rdata(l_rdata),
      .r_valid(r_valid), .r_sem_sel(r_sem_sel), .r_mem_en(r_mem_en), .r_lane_en(r_lane_en),
      .r_we(r_we), .r_idx(r_idx), .r_wbit(r_wbit), .r_rdata(r_rdata)
   );

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   // drive one cycle of operations, then sample just after the edge
   task automatic step(input logic [1:0] lop, input logic [2:0] lidx,
                       input logic [1:0] rop, input logic [2:0] ridx);
      @(negedge clk);
      l_valid = (lop != OP_IDLE); l_we = lop[1]; l_wbit = (lop == OP_REL); l_idx = lidx;
      r_valid = (rop != OP_IDLE); r_we = rop[1]; r_wbit = (rop == OP_REL); r_idx = ridx;
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(l_rdata, 16'hFFFF, "R1 left rdata in reset");
      check(r_rdata, 16'hFFFF, "R1 right rdata in reset");
      @(negedge clk);
      rst_n = 1'b1;

      for (int k = 0; k < NSTEP; k++) begin
         step(TBL[k].lop, TBL[k].lidx, TBL[k].rop, TBL[k].ridx);
         if (TBL[k].lchk)
            check(l_rdata, {16{TBL[k].lexp}}, $sformatf("R%0d left step %0d", TBL[k].tag, k));
         if (TBL[k].rchk)
            check(r_rdata, {16{TBL[k].rexp}}, $sformatf("R%0d right step %0d", TBL[k].tag, k));
      end
      step(OP_IDLE, 3'd0, OP_IDLE, 3'd0);

      // R2: semaphore select low blocks the request
      l_sem_sel = 1'b0;
      step(OP_REQ, 3'd1, OP_IDLE, 3'd0);
      l_sem_sel = 1'b1;
      // R2: memory enable with one lane on also blocks it
      l_mem_en = 1'b1; l_lane_en = 2'b01;
      step(OP_REQ, 3'd1, OP_IDLE, 3'd0);
      l_mem_en = 1'b0; l_lane_en = 2'b00;
      step(OP_RD, 3'd1, OP_RD, 3'd1);
      check(l_rdata, 16'hFFFF, "R2 gated requests ignored left");
      check(r_rdata, 16'hFFFF, "R2 gated requests ignored right");
      // R2: memory enable with both lanes off still lets the request through
      l_mem_en = 1'b1; l_lane_en = 2'b00;
      step(OP_REQ, 3'd1, OP_IDLE, 3'd0);
      l_mem_en = 1'b0;
      step(OP_RD, 3'd1, OP_IDLE, 3'd0);
      check(l_rdata, 16'h0000, "R2 lanes off request accepted");
      // R2: a gated read leaves rdata alone
      l_sem_sel = 1'b0;
      step(OP_RD, 3'd2, OP_IDLE, 3'd0);
      l_sem_sel = 1'b1;
      check(l_rdata, 16'h0000, "R2 gated read keeps rdata");
      // R4: rdata holds over idle cycles
      step(OP_IDLE, 3'd0, OP_IDLE, 3'd0);
      step(OP_IDLE, 3'd0, OP_IDLE, 3'd0);
      check(l_rdata, 16'h0000, "R4 hold while idle");

      // R1: reset mid-run drops ownership and the pending rival
      step(OP_IDLE, 3'd0, OP_REQ, 3'd1);
      @(negedge clk);
      l_valid = 1'b0; r_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      check(l_rdata, 16'hFFFF, "R1 left rdata after reset");
      @(negedge clk);
      rst_n = 1'b1;
      step(OP_RD, 3'd1, OP_RD, 3'd1);
      check(l_rdata, 16'hFFFF, "R1 flag free after reset left");
      check(r_rdata, 16'hFFFF, "R1 pending cleared by reset right");

      // R7: release and rival request arriving on the same edge
      step(OP_IDLE, 3'd0, OP_REQ, 3'd0);
      step(OP_REQ, 3'd0, OP_REL, 3'd0);
      step(OP_RD, 3'd0, OP_RD, 3'd0);
      check(l_rdata, 16'h0000, "R7 left granted as right releases");
      check(r_rdata, 16'hFFFF, "R7 right no longer holder");
      step(OP_IDLE, 3'd0, OP_IDLE, 3'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule